// File: doc/BRIEF.md
# Viterbi Traceback Decoder

This block performs the survivor-path stage of a Viterbi decoder once the add-compare-select stage has filled a window of decision words. On a start request it reads every path metric once, picks the best final state (smallest or largest metric, selectable), and then steps backward through the survivor memory. At each step it uses the current state to select one decision bit from the stored word, and it uses that bit to form the predecessor state. The recovered information bits are buffered and sent out in forward time order, one bit per cycle.

Two decoding modes are available. In single-bit mode a traceback of L steps yields one bit. In block mode a traceback of 2L steps yields the L oldest bits, which gives roughly 2 memory reads per decoded bit. The survivor-memory read latency is programmable. The read requests are issued on consecutive cycles and their returns are consumed in order, so one traceback step costs one cycle after the pipeline has filled. Survivor addresses count downward from a programmed newest address and wrap around the memory.

Top module: `vit_traceback`

## Requirements
- R1: After reset, busy, done, bitValid and smRdEn are all low.
- R2: The start state is the path-metric address 0..2^STATE_BITS-1 whose unsigned metric is smallest (cfgMaxSel=0) or largest (cfgMaxSel=1). On a tie the lowest state index wins.
- R3: Bit s of the decision word at survivor address a gives the predecessor of state s after step a as {bit, s[STATE_BITS-1:1]}. The information bit of step a is bit 0 of the state after step a.
- R4: With cfgBlockMode=0, exactly L reads are made at addresses E, E-1, ..., E-L+1 (E=cfgEndAddr). Exactly one bit is output: bit 0 of the state reached after L steps back.
- R5: With cfgBlockMode=1, exactly 2L reads are made. L bits are output: bit 0 of the states reached after steps L+1 through 2L. The oldest (step 2L) comes first and the rest follow in forward time order.
- R6: Survivor read data is taken exactly cfgLatency+1 cycles after the cycle in which smRdEn was high (cfgLatency 0..7). Reads may be issued on back-to-back cycles.
- R7: A start pulse while idle begins a run. busy stays high from the next cycle until the final bit. done is high for exactly one cycle, together with the final bitValid, and busy is low in that cycle. The block is idle afterwards.
- R8: bitValid is never high during the metric scan or while survivor reads are outstanding. The decoded bits of one run appear on consecutive cycles.
- R9: The configuration inputs are captured only when a start is accepted. A start pulse or configuration change while busy has no effect on the run in progress.
- R10: Survivor addresses wrap modulo 2^ADDR_WIDTH when counting below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a traceback when idle |
| cfgMaxSel | input | 1 | 1: best state has largest metric; 0: smallest |
| cfgBlockMode | input | 1 | 1: block mode (L bits from 2L steps); 0: single bit |
| cfgTbLen | input | LEN_W (7) | Traceback length L, 1..64 |
| cfgLatency | input | 3 | Survivor read latency minus one |
| cfgEndAddr | input | ADDR_WIDTH | Survivor address of the newest decision word |
| pmAddr | output | STATE_BITS | Path-metric read address |
| pmRdData | input | PM_WIDTH | Path metric, valid one cycle after pmAddr |
| smRdEn | output | 1 | Survivor read request |
| smAddr | output | ADDR_WIDTH | Survivor read address |
| smRdData | input | 2^STATE_BITS | Decision word, one bit per state |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| bitValid | output | 1 | Decoded bit valid |
| bitData | output | 1 | Decoded bit |

## Verification
The bound checker checks the handshake on every cycle: busy and done are never high together, done lasts one cycle and leads to idle, an idle cycle never issues a survivor read, and output never overlaps reads or falls outside a run. The decoded values cannot be checked that way. Best-state selection with ties, the trellis convention, both modes, the latency alignment, address wrap and the rejection of mid-run starts are shown only by the bench's scenarios, which compare each emitted bit with a reference traceback over random metrics and decision words.

// File: rtl/vtb_pkg.sv
package vtb_pkg;
  localparam int unsigned MAX_TB_LEN = 64;
  localparam int unsigned LEN_W      = $clog2(MAX_TB_LEN + 1);
  localparam int unsigned IDX_W      = $clog2(MAX_TB_LEN);
  localparam int unsigned STEP_W     = LEN_W + 1;
  localparam int unsigned LAT_W      = 3;
  localparam int unsigned LAT_SLOTS  = 1 << LAT_W;

  typedef struct packed {
    logic             pmCmp;
    logic             pmFirst;
    logic             maxSel;
    logic             step;
    logic             collect;
    logic [IDX_W-1:0] colIdx;
    logic             emit;
    logic [IDX_W-1:0] emitIdx;
  } tbStrobe_t;
endpackage

// File: rtl/vtb_ctrl.sv
module vtb_ctrl
  import vtb_pkg::*;
#(
  parameter int unsigned STATE_BITS = 6,
  parameter int unsigned ADDR_WIDTH = 10
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  start,
  input  logic                  cfgMaxSel,
  input  logic                  cfgBlockMode,
  input  logic [LEN_W-1:0]      cfgTbLen,
  input  logic [LAT_W-1:0]      cfgLatency,
  input  logic [ADDR_WIDTH-1:0] cfgEndAddr,
  output logic [STATE_BITS-1:0] pmAddr,
  output logic [STATE_BITS-1:0] cmpIdx,
  output logic                  smRdEn,
  output logic [ADDR_WIDTH-1:0] smAddr,
  output logic                  busy,
  output logic                  done,
  output tbStrobe_t             strb
);
  localparam int unsigned NSTATES = 1 << STATE_BITS;

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_TRACE, S_EMIT, S_DONE} phase_t;

  phase_t                phase;
  logic                  maxSelQ, blockQ;
  logic [LEN_W-1:0]      lenQ;
  logic [LAT_W-1:0]      latQ;
  logic [ADDR_WIDTH-1:0] endQ;
  logic [STATE_BITS:0]   scanCnt;
  logic [STEP_W-1:0]     issueCnt, recvCnt, stepsTotal, lenExt;
  logic [LAT_SLOTS-1:0]  validPipe;
  logic [IDX_W-1:0]      emitCnt;
  logic                  dataHere, lastRecv;

  assign lenExt     = {1'b0, lenQ};
  assign stepsTotal = blockQ ? {lenQ, 1'b0} : lenExt;
  assign dataHere   = (phase == S_TRACE) && validPipe[latQ];
  assign lastRecv   = (recvCnt + 1'b1) == stepsTotal;

  assign pmAddr = scanCnt[STATE_BITS-1:0];
  assign cmpIdx = STATE_BITS'(scanCnt - 1'b1);
  assign smRdEn = (phase == S_TRACE) && (issueCnt != stepsTotal);
  assign smAddr = endQ - ADDR_WIDTH'(issueCnt);
  assign busy   = (phase == S_SCAN) || (phase == S_TRACE) || (phase == S_EMIT);
  assign done   = (phase == S_DONE);

  always_comb begin
    strb         = '0;
    strb.maxSel  = maxSelQ;
    strb.pmCmp   = (phase == S_SCAN) && (scanCnt != '0);
    strb.pmFirst = (phase == S_SCAN) && (scanCnt == 1);
    strb.step    = dataHere;
    if (blockQ) begin
      strb.collect = dataHere && (recvCnt >= lenExt);
      strb.colIdx  = IDX_W'(recvCnt - lenExt);
    end else begin
      strb.collect = dataHere && ((recvCnt + 1'b1) == lenExt);
      strb.colIdx  = '0;
    end
    strb.emit    = (phase == S_EMIT);
    strb.emitIdx = emitCnt;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase     <= S_IDLE;
      maxSelQ   <= 1'b0;
      blockQ    <= 1'b0;
      lenQ      <= '0;
      latQ      <= '0;
      endQ      <= '0;
      scanCnt   <= '0;
      issueCnt  <= '0;
      recvCnt   <= '0;
      validPipe <= '0;
      emitCnt   <= '0;
    end else begin
      validPipe <= {validPipe[LAT_SLOTS-2:0], smRdEn};
      unique case (phase)
        S_IDLE: if (start) begin
          maxSelQ <= cfgMaxSel;
          blockQ  <= cfgBlockMode;
          lenQ    <= cfgTbLen;
          latQ    <= cfgLatency;
          endQ    <= cfgEndAddr;
          scanCnt <= '0;
          phase   <= S_SCAN;
        end
        S_SCAN: begin
          scanCnt <= scanCnt + 1'b1;
          if (scanCnt == NSTATES[STATE_BITS:0]) begin
            issueCnt <= '0;
            recvCnt  <= '0;
            phase    <= S_TRACE;
          end
        end
        S_TRACE: begin
          if (smRdEn) issueCnt <= issueCnt + 1'b1;
          if (dataHere) begin
            recvCnt <= recvCnt + 1'b1;
            if (lastRecv) begin
              emitCnt <= blockQ ? IDX_W'(lenQ - 1'b1) : '0;
              phase   <= S_EMIT;
            end
          end
        end
        S_EMIT: begin
          if (emitCnt == '0) phase <= S_DONE;
          else               emitCnt <= emitCnt - 1'b1;
        end
        default: phase <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/vtb_path.sv
module vtb_path
  import vtb_pkg::*;
#(
  parameter int unsigned STATE_BITS = 6,
  parameter int unsigned PM_WIDTH   = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  tbStrobe_t                  strb,
  input  logic [STATE_BITS-1:0]      cmpIdx,
  input  logic [PM_WIDTH-1:0]        pmRdData,
  input  logic [(1<<STATE_BITS)-1:0] smRdData,
  output logic                       bitValid,
  output logic                       bitData
);
  logic [PM_WIDTH-1:0]   bestPm;
  logic [STATE_BITS-1:0] curState, nextState;
  logic [MAX_TB_LEN-1:0] bitBuf;
  logic                  better;

  // Larger (or smaller) strictly: ties keep the earlier, lower index
  assign better    = strb.maxSel ? (pmRdData > bestPm) : (pmRdData < bestPm);
  assign nextState = {smRdData[curState], curState[STATE_BITS-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bestPm   <= '0;
      curState <= '0;
      bitBuf   <= '0;
      bitValid <= 1'b0;
      bitData  <= 1'b0;
    end else begin
      if (strb.pmCmp) begin
        if (strb.pmFirst || better) begin
          bestPm   <= pmRdData;
          curState <= cmpIdx;
        end
      end else if (strb.step) begin
        curState <= nextState;
      end
      if (strb.collect) bitBuf[strb.colIdx] <= nextState[0];
      bitValid <= strb.emit;
      bitData  <= strb.emit ? bitBuf[strb.emitIdx] : 1'b0;
    end
  end
endmodule

// File: rtl/vit_traceback.sv
module vit_traceback
  import vtb_pkg::*;
#(
  parameter int unsigned STATE_BITS = 6,
  parameter int unsigned PM_WIDTH   = 16,
  parameter int unsigned ADDR_WIDTH = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic                       cfgMaxSel,
  input  logic                       cfgBlockMode,
  input  logic [LEN_W-1:0]           cfgTbLen,
  input  logic [LAT_W-1:0]           cfgLatency,
  input  logic [ADDR_WIDTH-1:0]      cfgEndAddr,
  output logic [STATE_BITS-1:0]      pmAddr,
  input  logic [PM_WIDTH-1:0]        pmRdData,
  output logic                       smRdEn,
  output logic [ADDR_WIDTH-1:0]      smAddr,
  input  logic [(1<<STATE_BITS)-1:0] smRdData,
  output logic                       busy,
  output logic                       done,
  output logic                       bitValid,
  output logic                       bitData
);
  tbStrobe_t             strb;
  logic [STATE_BITS-1:0] cmpIdx;

  vtb_ctrl #(.STATE_BITS(STATE_BITS), .ADDR_WIDTH(ADDR_WIDTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .cfgMaxSel(cfgMaxSel), .cfgBlockMode(cfgBlockMode), .cfgTbLen(cfgTbLen),
    .cfgLatency(cfgLatency), .cfgEndAddr(cfgEndAddr),
    .pmAddr(pmAddr), .cmpIdx(cmpIdx), .smRdEn(smRdEn), .smAddr(smAddr),
    .busy(busy), .done(done), .strb(strb)
  );

  vtb_path #(.STATE_BITS(STATE_BITS), .PM_WIDTH(PM_WIDTH)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpIdx(cmpIdx),
    .pmRdData(pmRdData), .smRdData(smRdData),
    .bitValid(bitValid), .bitData(bitData)
  );
endmodule

// File: rtl/vtb_checker.sv
module vtb_checker (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic smRdEn,
  input logic bitValid
);
  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R7
  idle_no_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> !smRdEn);

  // R8
  no_out_while_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    smRdEn |-> !bitValid);

  // R8
  out_in_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitValid |-> (busy || done));
endmodule

bind vit_traceback vtb_checker u_vtb_checker (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done),
  .smRdEn(smRdEn), .bitValid(bitValid)
);

// File: tb/tb_vit_traceback.sv
module tb_vit_traceback;
  import vtb_pkg::*;

  localparam int SB = 6;
  localparam int NS = 1 << SB;
  localparam int PMW = 16;
  localparam int AW = 10;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic cfgMaxSel = 1'b0;
  logic cfgBlockMode = 1'b0;
  logic [LEN_W-1:0] cfgTbLen = '0;
  logic [LAT_W-1:0] cfgLatency = '0;
  logic [AW-1:0] cfgEndAddr = '0;
  logic [SB-1:0] pmAddr;
  logic [PMW-1:0] pmRdData;
  logic smRdEn;
  logic [AW-1:0] smAddr;
  logic [NS-1:0] smRdData;
  logic busy, done, bitValid, bitData;

  logic [PMW-1:0] pmMem [NS];
  logic [NS-1:0]  smMem [DEPTH];
  logic [NS-1:0]  rdPipe [LAT_SLOTS];
  int benchLat = 0;

  int total = 0;
  int bad = 0;
  logic expBits [MAX_TB_LEN];
  int expCount;
  int expReads;

  always #10 clk = ~clk;

  vit_traceback dut (
    .clk(clk), .rstN(rstN), .start(start), .cfgMaxSel(cfgMaxSel),
    .cfgBlockMode(cfgBlockMode), .cfgTbLen(cfgTbLen), .cfgLatency(cfgLatency),
    .cfgEndAddr(cfgEndAddr), .pmAddr(pmAddr), .pmRdData(pmRdData),
    .smRdEn(smRdEn), .smAddr(smAddr), .smRdData(smRdData),
    .busy(busy), .done(done), .bitValid(bitValid), .bitData(bitData)
  );

  always_ff @(posedge clk) pmRdData <= pmMem[pmAddr];

  always_ff @(posedge clk) begin
    rdPipe[0] <= smRdEn ? smMem[smAddr] : '0;
    for (int k = 1; k < LAT_SLOTS; k++) rdPipe[k] <= rdPipe[k-1];
  end
  assign smRdData = rdPipe[benchLat];

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference traceback following the trellis convention of R3
  task automatic model(input logic maxSel, input logic blk, input int len, input int endA);
    int best;
    logic [SB-1:0] st;
    logic tmp [MAX_TB_LEN];
    int steps;
    best = 0;
    for (int s = 1; s < NS; s++)
      if (maxSel ? (pmMem[s] > pmMem[best]) : (pmMem[s] < pmMem[best])) best = s;
    st = SB'(best);
    steps = blk ? 2 * len : len;
    for (int n = 1; n <= steps; n++) begin
      int a;
      logic d;
      a = (endA - (n - 1)) & (DEPTH - 1);
      d = smMem[a][st];
      st = {d, st[SB-1:1]};
      if (!blk && n == len) expBits[0] = st[0];
      if (blk && n > len) tmp[n-len-1] = st[0];
    end
    if (blk) for (int j = 0; j < len; j++) expBits[j] = tmp[len-1-j];
    expCount = blk ? len : 1;
    expReads = steps;
  endtask

  task automatic run_case(input logic maxSel, input logic blk, input int len,
                          input int lat, input int endA, input bit disturb,
                          input string tag);
    int got, reads, cyc, firstCyc, lastCyc;
    bit seenDone;
    @(negedge clk);
    cfgMaxSel = maxSel; cfgBlockMode = blk; cfgTbLen = LEN_W'(len);
    cfgLatency = LAT_W'(lat); cfgEndAddr = AW'(endA); benchLat = lat;
    start = 1'b1;
    model(maxSel, blk, len, endA);
    @(negedge clk);
    start = 1'b0;
    got = 0; reads = 0; cyc = 0; firstCyc = -1; lastCyc = -1; seenDone = 0;
    while (!seenDone && cyc < 6000) begin
      if (disturb && cyc == 5) begin
        start = 1'b1; cfgMaxSel = ~maxSel; cfgBlockMode = ~blk;
        cfgTbLen = LEN_W'(($urandom % 30) + 1); cfgEndAddr = AW'($urandom);
        cfgLatency = LAT_W'(lat ^ 1);
      end
      if (disturb && cyc == 6) start = 1'b0;
      if (smRdEn) reads++;
      if (bitValid) begin
        if (firstCyc < 0) firstCyc = cyc;
        lastCyc = cyc;
        if (got < expCount)
          check(bitData == expBits[got], tag, int'(bitData), int'(expBits[got]));
        got++;
      end
      if (done) begin
        seenDone = 1;
        // R7: done coincides with the last bit and busy is already low
        check(bitValid && !busy, "R7 done with last bit", int'({bitValid, busy}), 2);
      end
      cyc++;
      if (!seenDone) @(negedge clk);
    end
    check(seenDone, "R7 run completes", int'(seenDone), 1);
    check(got == expCount, blk ? "R5 bit count" : "R4 bit count", got, expCount);
    check(reads == expReads, blk ? "R5 read count" : "R4 read count", reads, expReads);
    // R8: bits of one run on consecutive cycles
    check(lastCyc - firstCyc + 1 == got, "R8 contiguous output", lastCyc - firstCyc + 1, got);
    @(negedge clk);
    check(!busy && !done && !bitValid, "R7 idle after done", int'({busy, done, bitValid}), 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int s = 0; s < NS; s++) pmMem[s] = PMW'($urandom);
    for (int a = 0; a < DEPTH; a++) smMem[a] = {$urandom, $urandom};
    for (int k = 0; k < LAT_SLOTS; k++) rdPipe[k] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !done && !bitValid && !smRdEn, "R1 reset outputs",
          int'({busy, done, bitValid, smRdEn}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !done && !bitValid && !smRdEn, "R1 idle after reset",
          int'({busy, done, bitValid, smRdEn}), 0);

    // R4 single-bit mode, typical length, 3-cycle access (R6)
    run_case(1'b0, 1'b0, 40, 2, 600, 0, "R4 R3 R6 bit");
    // R5 block mode, maximum selection
    run_case(1'b1, 1'b1, 40, 2, 700, 0, "R5 R3 bit");
    // R6 latency extremes
    run_case(1'b0, 1'b1, 17, 0, 300, 0, "R6 lat0 bit");
    run_case(1'b1, 1'b1, 17, 7, 300, 0, "R6 lat7 bit");
    // Length boundaries
    run_case(1'b0, 1'b0, 1, 1, 50, 0, "R4 L1 bit");
    run_case(1'b0, 1'b1, 1, 1, 50, 0, "R5 L1 bit");
    run_case(1'b1, 1'b1, 64, 3, 900, 0, "R5 Lmax bit");
    // R10 address wrap below zero
    run_case(1'b0, 1'b1, 20, 2, 5, 0, "R10 wrap bit");
    run_case(1'b1, 1'b0, 30, 4, 0, 0, "R10 wrap0 bit");
    // R9 start and config changes mid-run are ignored
    run_case(1'b0, 1'b1, 24, 2, 400, 1, "R9 disturb bit");
    run_case(1'b1, 1'b0, 24, 5, 400, 1, "R9 disturb1 bit");
    // R2 ties: lowest index wins for both polarities
    for (int s = 0; s < NS; s++) pmMem[s] = 16'd1000;
    pmMem[17] = 16'd5; pmMem[42] = 16'd5;
    run_case(1'b0, 1'b1, 30, 2, 512, 0, "R2 min tie bit");
    pmMem[17] = 16'd1000; pmMem[42] = 16'd1000;
    pmMem[9] = 16'hFFFF; pmMem[50] = 16'hFFFF;
    run_case(1'b1, 1'b1, 30, 2, 512, 0, "R2 max tie bit");
    for (int s = 0; s < NS; s++) pmMem[s] = 16'd77;
    run_case(1'b0, 1'b0, 12, 1, 128, 0, "R2 all equal bit");

    // Constrained random runs
    for (int r = 0; r < 60; r++) begin
      for (int s = 0; s < NS; s++) pmMem[s] = PMW'($urandom % ((r % 3 == 0) ? 8 : 65536));
      for (int a = 0; a < 64; a++) smMem[$urandom % DEPTH] = {$urandom, $urandom};
      run_case(1'($urandom), 1'($urandom), int'($urandom % MAX_TB_LEN) + 1,
               int'($urandom % LAT_SLOTS), int'($urandom % DEPTH), (r % 7) == 3,
               "R3 R2 random bit");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule